// File: doc/BRIEF.md
# Register-Offset Load/Store Address Unit

This block turns the operands of a load or store that uses a register offset into a memory address and a base-register update. The offset register value first goes through a shifter with five shift kinds. The shifted value is then added to or subtracted from the base. Three indexing modes decide which value is used as the address and whether the base is rewritten. The block also widens raw load data to the full word by zero or sign extension, according to the access-size code.

A request strobe captures the operands. The address, the writeback enable, the writeback value and the illegal flag appear one clock later, together with a valid pulse. Alongside the arithmetic, a rule checker sets the illegal flag for operand combinations that are not allowed. Any request with the illegal flag set never asserts writeback. The load extender is combinational and uses the current size code, so it can sit directly on the memory return path.

Top module: `regoff_agu`

## Requirements
- R1: When `sub_offs` is 0 the shifted offset is added to `base_val`; when it is 1 it is subtracted (modulo 2^32).
- R2: Shift kind codes are LSL=0, LSR=1, ASR=2, ROR=3 and RRX=4. LSR by 32 yields zero. ASR by 32 yields every bit equal to bit 31 of the offset. ROR rotates right by the amount.
- R3: RRX ignores `shift_amt`. It shifts the offset right by one bit and places `carry_in` in bit 31.
- R4: Index mode 0 (offset only): the address is base ± shifted offset and `wb_en` stays 0.
- R5: Index mode 1 (pre-indexed): the address and `wb_value` both equal base ± shifted offset, and `wb_en` is 1 for a legal request.
- R6: Index mode 2 (post-indexed): the address equals the unmodified base, `wb_value` is base ± shifted offset, and `wb_en` is 1 for a legal request.
- R7: `out_valid` pulses exactly one cycle after each cycle with `req_valid` high. `mem_addr`, `wb_value` and `illegal` keep their values while no request arrives, and `wb_en` is 0 in such cycles.
- R8: Size codes are 0 word, 1 unsigned byte, 2 signed byte, 3 unsigned halfword, 4 signed halfword, 5 doubleword. `load_ext` zero-extends codes 1 and 3 and sign-extends codes 2 and 4 from bit 7 or bit 15. It passes `load_raw` through for the other codes.
- R9: A shift amount outside the allowed range for its kind is illegal. The ranges are LSL 0–31, LSR 1–32, ASR 1–32 and ROR 1–31. Shift kind codes 5–7 are also illegal.
- R10: For size codes 2, 3, 4 and 5, any shift other than LSL by 0 is illegal. Codes 0 and 1 accept the full shift set.
- R11: A store (`is_load`=0) with size code 2 or 4 is illegal. The same code on a load is legal.
- R12: For size code 5, `first_reg` must be even and not 14, and `second_reg` must equal `first_reg`+1. Otherwise the request is illegal.
- R13: With `compact_mode`=1, any of the following is illegal: subtraction, any shift other than LSL 0–3, or an index mode other than 0.
- R14: Index mode 3 and size codes 6–7 are illegal. Every illegal request leaves `wb_en` at 0, although the address is still computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe; operands are sampled in this cycle |
| base_val | input | 32 | Base register value |
| offs_val | input | 32 | Offset register value before shifting |
| sub_offs | input | 1 | 1 subtracts the shifted offset from the base |
| shift_kind | input | 3 | Shift kind code (R2) |
| shift_amt | input | 6 | Shift amount |
| carry_in | input | 1 | Carry flag fed into bit 31 by RRX |
| idx_mode | input | 2 | 0 offset only, 1 pre-indexed, 2 post-indexed |
| acc_size | input | 3 | Access-size and signedness code (R8) |
| is_load | input | 1 | 1 for a load, 0 for a store |
| first_reg | input | 4 | Index of the first transfer register |
| second_reg | input | 4 | Index of the second transfer register (doubleword) |
| compact_mode | input | 1 | Selects the restricted compact encoding rules |
| load_raw | input | 32 | Raw data returned by memory |
| out_valid | output | 1 | Result valid, one cycle after the request |
| mem_addr | output | 32 | Effective memory address |
| wb_en | output | 1 | Base-register writeback enable |
| wb_value | output | 32 | Value to write back to the base register |
| illegal | output | 1 | Operand combination not allowed |
| load_ext | output | 32 | Load data extended to 32 bits |

## Verification
The properties assume that operand inputs are only meaningful in a cycle with `req_valid` high. They also assume that `acc_size` and `load_raw` can change at any time, because the extender is combinational. The bench changes every input only on the falling clock edge, keeps `req_valid` low throughout reset, and holds each request for exactly one cycle. These conditions are what the one-cycle `$past` relations in the checker require. Illegal cases are sent as single strobes with one rule broken at a time. Every failing illegal flag can therefore be traced to a single requirement, and `wb_en` is observed to stay low for it.

// File: rtl/regoff_agu_pkg.sv
package regoff_agu_pkg;

   // shift kinds (R2, R3)
   localparam logic [2:0] SHK_LSL = 3'd0;
   localparam logic [2:0] SHK_LSR = 3'd1;
   localparam logic [2:0] SHK_ASR = 3'd2;
   localparam logic [2:0] SHK_ROR = 3'd3;
   localparam logic [2:0] SHK_RRX = 3'd4;

   // indexing modes (R4..R6, R14)
   localparam logic [1:0] IDX_OFFSET = 2'd0;
   localparam logic [1:0] IDX_PRE    = 2'd1;
   localparam logic [1:0] IDX_POST   = 2'd2;

   // access sizes (R8)
   localparam logic [2:0] SZ_WORD  = 3'd0;
   localparam logic [2:0] SZ_UBYTE = 3'd1;
   localparam logic [2:0] SZ_SBYTE = 3'd2;
   localparam logic [2:0] SZ_UHALF = 3'd3;
   localparam logic [2:0] SZ_SHALF = 3'd4;
   localparam logic [2:0] SZ_DWORD = 3'd5;

endpackage

// File: rtl/regoff_shifter.sv
module regoff_shifter
   import regoff_agu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int AMT_W     = 6,
   parameter int ROT_STYLE = 0
) (
   input  logic [DATA_W-1:0] opnd,
   input  logic [2:0]        kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              cin,
   output logic [DATA_W-1:0] result
);
   localparam int              LOG_W = $clog2(DATA_W);
   localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

   logic [DATA_W-1:0] rot_val;
   logic [LOG_W-1:0]  rot_amt;

   assign rot_amt = amt[LOG_W-1:0];

   generate
      if (ROT_STYLE == 0) begin : g_rot_dbl
         logic [2*DATA_W-1:0] dbl;
         always_comb begin
            dbl     = {opnd, opnd} >> rot_amt;
            rot_val = dbl[DATA_W-1:0];
         end
      end else begin : g_rot_or
         logic [LOG_W-1:0] back_amt;
         always_comb begin
            back_amt = LOG_W'(DATA_W - int'(rot_amt));
            if (rot_amt == '0) rot_val = opnd;
            else               rot_val = (opnd >> rot_amt) | (opnd << back_amt);
         end
      end
   endgenerate

   always_comb begin
      case (kind)
         SHK_LSL: result = (amt >= FULL) ? '0 : (opnd << amt);
         SHK_LSR: result = (amt >= FULL) ? '0 : (opnd >> amt);
         SHK_ASR: begin
            if (amt >= FULL) result = {DATA_W{opnd[DATA_W-1]}};
            else             result = DATA_W'($signed(opnd) >>> amt);
         end
         SHK_ROR: result = rot_val;
         SHK_RRX: result = {cin, opnd[DATA_W-1:1]};
         default: result = opnd;
      endcase
   end

endmodule

// File: rtl/regoff_legal.sv
module regoff_legal
   import regoff_agu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int AMT_W       = 6,
   parameter int REG_W       = 4,
   parameter int LINK_REG    = 14,
   parameter int COMPACT_MAX = 3
) (
   input  logic [2:0]       kind,
   input  logic [AMT_W-1:0] amt,
   input  logic [2:0]       size,
   input  logic             is_load,
   input  logic [1:0]       idx_mode,
   input  logic             sub_offs,
   input  logic             compact,
   input  logic [REG_W-1:0] first_reg,
   input  logic [REG_W-1:0] second_reg,
   output logic             bad
);
   localparam logic [AMT_W-1:0] MAX_LEFT = AMT_W'(DATA_W - 1);
   localparam logic [AMT_W-1:0] MAX_RIGHT = AMT_W'(DATA_W);
   localparam logic [AMT_W-1:0] CMAX = AMT_W'(COMPACT_MAX);
   localparam logic [REG_W-1:0] LINK = REG_W'(LINK_REG);

   logic range_bad, shift_none, word_like, size_bad, noshift_bad;
   logic signed_store, pair_bad, compact_bad, mode_bad;

   always_comb begin
      case (kind)
         SHK_LSL: range_bad = (amt > MAX_LEFT);
         SHK_LSR,
         SHK_ASR: range_bad = (amt == '0) || (amt > MAX_RIGHT);
         SHK_ROR: range_bad = (amt == '0) || (amt > MAX_LEFT);
         SHK_RRX: range_bad = 1'b0;
         default: range_bad = 1'b1;
      endcase
   end

   assign shift_none   = (kind == SHK_LSL) && (amt == '0);
   assign word_like    = (size == SZ_WORD) || (size == SZ_UBYTE);
   assign size_bad     = (size > SZ_DWORD);
   assign noshift_bad  = !size_bad && !word_like && !shift_none;
   assign signed_store = !is_load && ((size == SZ_SBYTE) || (size == SZ_SHALF));
   assign pair_bad     = (size == SZ_DWORD) &&
                         (first_reg[0] || (first_reg == LINK) ||
                          (second_reg != REG_W'(first_reg + 1'b1)));
   assign compact_bad  = compact &&
                         (sub_offs || (kind != SHK_LSL) || (amt > CMAX) ||
                          (idx_mode != IDX_OFFSET));
   assign mode_bad     = (idx_mode == 2'd3);

   assign bad = range_bad | size_bad | noshift_bad | signed_store |
                pair_bad | compact_bad | mode_bad;

endmodule

// File: rtl/regoff_ldext.sv
module regoff_ldext
   import regoff_agu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        size,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] ext
);
   localparam int HALF_W = 16;
   localparam int BYTE_W = 8;

   always_comb begin
      case (size)
         SZ_UBYTE: ext = {{(DATA_W-BYTE_W){1'b0}}, raw[BYTE_W-1:0]};
         SZ_SBYTE: ext = {{(DATA_W-BYTE_W){raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
         SZ_UHALF: ext = {{(DATA_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
         SZ_SHALF: ext = {{(DATA_W-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
         default:  ext = raw;
      endcase
   end

endmodule

// File: rtl/regoff_agu.sv
module regoff_agu
   import regoff_agu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int AMT_W       = 6,
   parameter int REG_W       = 4,
   parameter int LINK_REG    = 14,
   parameter int COMPACT_MAX = 3,
   parameter int ROT_STYLE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] offs_val,
   input  logic              sub_offs,
   input  logic [2:0]        shift_kind,
   input  logic [AMT_W-1:0]  shift_amt,
   input  logic              carry_in,
   input  logic [1:0]        idx_mode,
   input  logic [2:0]        acc_size,
   input  logic              is_load,
   input  logic [REG_W-1:0]  first_reg,
   input  logic [REG_W-1:0]  second_reg,
   input  logic              compact_mode,
   input  logic [DATA_W-1:0] load_raw,
   output logic              out_valid,
   output logic [DATA_W-1:0] mem_addr,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_value,
   output logic              illegal,
   output logic [DATA_W-1:0] load_ext
);
   generate
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("regoff_agu: DATA_W must be a power of two of at least 16");
      end
      if ((1 << (AMT_W - 1)) < DATA_W) begin : g_bad_amt
         $error("regoff_agu: AMT_W too narrow to encode a full-width shift");
      end
      if (LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("regoff_agu: LINK_REG outside register index range");
      end
      if (ROT_STYLE < 0 || ROT_STYLE > 1) begin : g_bad_rot
         $error("regoff_agu: ROT_STYLE must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] indexed;
   logic [DATA_W-1:0] next_addr;
   logic              next_wb;
   logic              rule_bad;

   regoff_shifter #(
      .DATA_W   (DATA_W),
      .AMT_W    (AMT_W),
      .ROT_STYLE(ROT_STYLE)
   ) u_shift (
      .opnd  (offs_val),
      .kind  (shift_kind),
      .amt   (shift_amt),
      .cin   (carry_in),
      .result(shifted)
   );

   regoff_legal #(
      .DATA_W     (DATA_W),
      .AMT_W      (AMT_W),
      .REG_W      (REG_W),
      .LINK_REG   (LINK_REG),
      .COMPACT_MAX(COMPACT_MAX)
   ) u_legal (
      .kind      (shift_kind),
      .amt       (shift_amt),
      .size      (acc_size),
      .is_load   (is_load),
      .idx_mode  (idx_mode),
      .sub_offs  (sub_offs),
      .compact   (compact_mode),
      .first_reg (first_reg),
      .second_reg(second_reg),
      .bad       (rule_bad)
   );

   regoff_ldext #(
      .DATA_W(DATA_W)
   ) u_ldext (
      .size(acc_size),
      .raw (load_raw),
      .ext (load_ext)
   );

   assign indexed   = sub_offs ? (base_val - shifted) : (base_val + shifted);
   assign next_addr = (idx_mode == IDX_POST) ? base_val : indexed;
   assign next_wb   = !rule_bad && ((idx_mode == IDX_PRE) || (idx_mode == IDX_POST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wb_en     <= 1'b0;
         mem_addr  <= '0;
         wb_value  <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= req_valid;
         wb_en     <= req_valid && next_wb;
         if (req_valid) begin
            mem_addr <= next_addr;
            wb_value <= indexed;
            illegal  <= rule_bad;
         end
      end
   end

endmodule

// File: rtl/regoff_agu_chk.sv
module regoff_agu_chk
   import regoff_agu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [DATA_W-1:0] base_val,
   input logic              sub_offs,
   input logic [1:0]        idx_mode,
   input logic [2:0]        acc_size,
   input logic              is_load,
   input logic [REG_W-1:0]  first_reg,
   input logic              compact_mode,
   input logic              out_valid,
   input logic [DATA_W-1:0] mem_addr,
   input logic              wb_en,
   input logic [DATA_W-1:0] wb_value,
   input logic              illegal,
   input logic [DATA_W-1:0] load_ext
);

   AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid); // R7

   AST_NO_VALID_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && !wb_en && $stable(mem_addr))); // R7

   AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && idx_mode == IDX_OFFSET) |=> !wb_en); // R4

   AST_PRE_ADDR_IS_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && idx_mode == IDX_PRE) |=> (mem_addr == wb_value)); // R5

   AST_POST_ADDR_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && idx_mode == IDX_POST) |=> (mem_addr == $past(base_val))); // R6

   AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && illegal) |-> !wb_en); // R14

   AST_SIGNED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !is_load && (acc_size == SZ_SBYTE || acc_size == SZ_SHALF))
      |=> illegal); // R11

   AST_ODD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && acc_size == SZ_DWORD && first_reg[0]) |=> illegal); // R12

   AST_COMPACT_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && compact_mode && sub_offs) |=> illegal); // R13

   AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_size == SZ_UBYTE) |-> (load_ext[DATA_W-1:8] == '0)); // R8

endmodule

bind regoff_agu regoff_agu_chk #(
   .DATA_W(DATA_W),
   .REG_W (REG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .base_val    (base_val),
   .sub_offs    (sub_offs),
   .idx_mode    (idx_mode),
   .acc_size    (acc_size),
   .is_load     (is_load),
   .first_reg   (first_reg),
   .compact_mode(compact_mode),
   .out_valid   (out_valid),
   .mem_addr    (mem_addr),
   .wb_en       (wb_en),
   .wb_value    (wb_value),
   .illegal     (illegal),
   .load_ext    (load_ext)
);

// File: tb/regoff_agu_bench.sv
module regoff_agu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] base_val = '0;
   logic [31:0] offs_val = '0;
   logic        sub_offs = 1'b0;
   logic [2:0]  shift_kind = '0;
   logic [5:0]  shift_amt = '0;
   logic        carry_in = 1'b0;
   logic [1:0]  idx_mode = '0;
   logic [2:0]  acc_size = '0;
   logic        is_load = 1'b1;
   logic [3:0]  first_reg = '0;
   logic [3:0]  second_reg = 4'd1;
   logic        compact_mode = 1'b0;
   logic [31:0] load_raw = '0;
   logic        out_valid, wb_en, illegal;
   logic [31:0] mem_addr, wb_value, load_ext;

   int checks = 0;
   int errors = 0;

   regoff_agu u_regoff_agu (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .base_val(base_val), .offs_val(offs_val), .sub_offs(sub_offs),
      .shift_kind(shift_kind), .shift_amt(shift_amt), .carry_in(carry_in),
      .idx_mode(idx_mode), .acc_size(acc_size), .is_load(is_load),
      .first_reg(first_reg), .second_reg(second_reg),
      .compact_mode(compact_mode), .load_raw(load_raw),
      .out_valid(out_valid), .mem_addr(mem_addr), .wb_en(wb_en),
      .wb_value(wb_value), .illegal(illegal), .load_ext(load_ext)
   );

   always #5 clk = ~clk;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic defaults();
      base_val = '0; offs_val = '0; sub_offs = 1'b0; shift_kind = 3'd0;
      shift_amt = '0; carry_in = 1'b0; idx_mode = 2'd0; acc_size = 3'd0;
      is_load = 1'b1; first_reg = 4'd0; second_reg = 4'd1; compact_mode = 1'b0;
   endtask

   // called at a falling edge; returns at the next falling edge with results visible
   task automatic fire();
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic shift_case(input logic [2:0] k, input logic [5:0] a,
                             input logic [31:0] off, input logic [31:0] exp, input string rq);
      defaults(); shift_kind = k; shift_amt = a; offs_val = off;
      fire();
      chk(rq, mem_addr, exp);
      chk(rq, {31'd0, illegal}, 32'd0);
   endtask

   task automatic legal_case(input string rq, input logic exp_bad);
      fire();
      chk(rq, {31'd0, illegal}, {31'd0, exp_bad});
      if (exp_bad) chk(rq, {31'd0, wb_en}, 32'd0);
   endtask

   task automatic t_reset();
      chk("R7 reset valid", {31'd0, out_valid}, 32'd0);
      chk("R7 reset wb_en", {31'd0, wb_en}, 32'd0);
      chk("R7 reset addr", mem_addr, 32'd0);
      chk("R14 reset illegal", {31'd0, illegal}, 32'd0);
   endtask

   task automatic t_addsub();
      defaults(); base_val = 32'h1000; offs_val = 32'h10;
      fire();
      chk("R1 add", mem_addr, 32'h1010);
      chk("R4 no wb", {31'd0, wb_en}, 32'd0);
      defaults(); base_val = 32'h1000; offs_val = 32'h10; sub_offs = 1'b1;
      fire();
      chk("R1 sub", mem_addr, 32'h0FF0);
      defaults(); base_val = 32'h4; offs_val = 32'h8; sub_offs = 1'b1;
      fire();
      chk("R1 sub wrap", mem_addr, 32'hFFFF_FFFC);
   endtask

   task automatic t_shifts();
      shift_case(3'd0, 6'd4,  32'h8000_0001, 32'h0000_0010, "R2 lsl4");
      shift_case(3'd1, 6'd1,  32'h8000_0001, 32'h4000_0000, "R2 lsr1");
      shift_case(3'd1, 6'd32, 32'h8000_0001, 32'h0000_0000, "R2 lsr32");
      shift_case(3'd2, 6'd4,  32'h8000_0001, 32'hF800_0000, "R2 asr4");
      shift_case(3'd2, 6'd32, 32'h8000_0001, 32'hFFFF_FFFF, "R2 asr32");
      shift_case(3'd2, 6'd32, 32'h7000_0001, 32'h0000_0000, "R2 asr32 pos");
      shift_case(3'd3, 6'd1,  32'h8000_0001, 32'hC000_0000, "R2 ror1");
      shift_case(3'd3, 6'd31, 32'h8000_0001, 32'h0000_0003, "R2 ror31");
   endtask

   task automatic t_rrx();
      defaults(); shift_kind = 3'd4; shift_amt = 6'd7; offs_val = 32'h3; carry_in = 1'b1;
      fire();
      chk("R3 rrx c1", mem_addr, 32'h8000_0001);
      defaults(); shift_kind = 3'd4; offs_val = 32'h3; carry_in = 1'b0;
      fire();
      chk("R3 rrx c0", mem_addr, 32'h0000_0001);
   endtask

   task automatic t_pre_post();
      defaults(); base_val = 32'h2000; offs_val = 32'h4; shift_amt = 6'd2; idx_mode = 2'd1;
      fire();
      chk("R5 pre addr", mem_addr, 32'h2010);
      chk("R5 pre wb", wb_value, 32'h2010);
      chk("R5 pre wb_en", {31'd0, wb_en}, 32'd1);
      defaults(); base_val = 32'h2000; offs_val = 32'h4; shift_amt = 6'd2; idx_mode = 2'd2;
      fire();
      chk("R6 post addr", mem_addr, 32'h2000);
      chk("R6 post wb", wb_value, 32'h2010);
      chk("R6 post wb_en", {31'd0, wb_en}, 32'd1);
      defaults(); base_val = 32'h2000; offs_val = 32'h10; sub_offs = 1'b1; idx_mode = 2'd2;
      fire();
      chk("R6 post sub wb", wb_value, 32'h1FF0);
   endtask

   task automatic t_hold();
      defaults(); base_val = 32'h300; offs_val = 32'h5; idx_mode = 2'd1;
      fire();
      chk("R7 valid pulse", {31'd0, out_valid}, 32'd1);
      base_val = 32'h9999; idx_mode = 2'd2;
      @(negedge clk);
      chk("R7 valid drops", {31'd0, out_valid}, 32'd0);
      chk("R7 addr held", mem_addr, 32'h305);
      chk("R7 wb_en low", {31'd0, wb_en}, 32'd0);
   endtask

   task automatic t_loadext();
      load_raw = 32'h1234_5680;
      acc_size = 3'd1; #1 chk("R8 ubyte", load_ext, 32'h0000_0080);
      acc_size = 3'd2; #1 chk("R8 sbyte", load_ext, 32'hFFFF_FF80);
      acc_size = 3'd3; #1 chk("R8 uhalf", load_ext, 32'h0000_5680);
      acc_size = 3'd4; #1 chk("R8 shalf pos", load_ext, 32'h0000_5680);
      load_raw = 32'hABCD_8001;
      acc_size = 3'd4; #1 chk("R8 shalf neg", load_ext, 32'hFFFF_8001);
      acc_size = 3'd0; #1 chk("R8 word", load_ext, 32'hABCD_8001);
      @(negedge clk);
   endtask

   task automatic t_range();
      defaults(); shift_kind = 3'd0; shift_amt = 6'd32; legal_case("R9 lsl32", 1'b1);
      defaults(); shift_kind = 3'd1; shift_amt = 6'd0;  legal_case("R9 lsr0", 1'b1);
      defaults(); shift_kind = 3'd2; shift_amt = 6'd33; legal_case("R9 asr33", 1'b1);
      defaults(); shift_kind = 3'd3; shift_amt = 6'd32; legal_case("R9 ror32", 1'b1);
      defaults(); shift_kind = 3'd5;                    legal_case("R9 kind5", 1'b1);
      defaults(); shift_kind = 3'd0; shift_amt = 6'd31; legal_case("R9 lsl31", 1'b0);
   endtask

   task automatic t_nonword();
      defaults(); acc_size = 3'd1; shift_amt = 6'd3;           legal_case("R10 ubyte shift", 1'b0);
      defaults(); acc_size = 3'd3; shift_amt = 6'd1;           legal_case("R10 uhalf lsl1", 1'b1);
      defaults(); acc_size = 3'd2; shift_kind = 3'd4;          legal_case("R10 sbyte rrx", 1'b1);
      defaults(); acc_size = 3'd3;                             legal_case("R10 uhalf plain", 1'b0);
   endtask

   task automatic t_signed_store();
      defaults(); acc_size = 3'd2; is_load = 1'b0; legal_case("R11 sbyte store", 1'b1);
      defaults(); acc_size = 3'd4; is_load = 1'b0; legal_case("R11 shalf store", 1'b1);
      defaults(); acc_size = 3'd4; is_load = 1'b1; legal_case("R11 shalf load", 1'b0);
      defaults(); acc_size = 3'd3; is_load = 1'b0; legal_case("R11 uhalf store", 1'b0);
   endtask

   task automatic t_pair();
      defaults(); acc_size = 3'd5; first_reg = 4'd2;  second_reg = 4'd3;  legal_case("R12 pair ok", 1'b0);
      defaults(); acc_size = 3'd5; first_reg = 4'd3;  second_reg = 4'd4;  legal_case("R12 odd", 1'b1);
      defaults(); acc_size = 3'd5; first_reg = 4'd14; second_reg = 4'd15; legal_case("R12 link", 1'b1);
      defaults(); acc_size = 3'd5; first_reg = 4'd4;  second_reg = 4'd6;  legal_case("R12 gap", 1'b1);
      defaults(); acc_size = 3'd5; first_reg = 4'd5;  second_reg = 4'd6; idx_mode = 2'd1;
      legal_case("R12 odd pre blocks wb", 1'b1);
   endtask

   task automatic t_compact();
      defaults(); compact_mode = 1'b1; shift_amt = 6'd3; base_val = 32'h100; offs_val = 32'h2;
      legal_case("R13 lsl3 ok", 1'b0);
      chk("R13 lsl3 addr", mem_addr, 32'h110);
      defaults(); compact_mode = 1'b1; shift_amt = 6'd4;   legal_case("R13 lsl4", 1'b1);
      defaults(); compact_mode = 1'b1; sub_offs = 1'b1;    legal_case("R13 sub", 1'b1);
      defaults(); compact_mode = 1'b1; idx_mode = 2'd1;    legal_case("R13 pre", 1'b1);
      defaults(); compact_mode = 1'b1; shift_kind = 3'd3; shift_amt = 6'd1;
      legal_case("R13 ror", 1'b1);
   endtask

   task automatic t_badmode();
      defaults(); idx_mode = 2'd3; base_val = 32'h40; offs_val = 32'h4;
      legal_case("R14 mode3", 1'b1);
      chk("R14 mode3 addr", mem_addr, 32'h44);
      defaults(); acc_size = 3'd6; legal_case("R14 size6", 1'b1);
      defaults(); acc_size = 3'd2; is_load = 1'b0; idx_mode = 2'd2;
      legal_case("R14 illegal post no wb", 1'b1);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addsub();
      t_shifts();
      t_rrx();
      t_pre_post();
      t_hold();
      t_loadext();
      t_range();
      t_nonword();
      t_signed_store();
      t_pair();
      t_compact();
      t_badmode();
      summary();
   end

endmodule